// File: doc/BRIEF.md
# Four-Channel LED Dimming and Blinking PWM Engine

This block turns a set of register values into the drive for four active-low LED pins. Every channel has its own 8-bit brightness PWM on a fast 256-count cycle. A shared 8-bit group controller produces a slower gating signal. That signal either dims every channel on a fixed slow period or blinks them on a programmable period. Each channel picks one of four drive modes: dark, fully lit, own PWM, or own PWM gated by the group signal.

A pin is lit when it is driven LOW. An active-low enable input, when HIGH, replaces every pin with a chosen override of driven LOW, driven HIGH or released. This override acts combinationally, outside the clocked path. A configuration bit turns the pins from push-pull into open-drain, where a logic HIGH releases the pin.

The group controller is a two-state machine. In state GS_DIM its phase counter steps every DIM_DIV clocks. In state GS_BLINK its phase counter steps every (freq+1) base ticks, with one base tick every BLINK_DIV clocks. The machine leaves reset in GS_DIM. It changes state only when the phase counter wraps. Transition ARM_BLINK goes from GS_DIM to GS_BLINK when the blink select is set at a wrap. Transition ARM_DIM goes from GS_BLINK back to GS_DIM when the blink select is clear at a wrap. Every other cycle holds the current state.

Top module: `led_dim_blink`

## Requirements
- R1: While reset is held, every channel is dark. With the enable input LOW and push-pull drive, each pin reads level 1 with drive enable 1, whatever the mode inputs are.
- R2: Mode code 2'b00 keeps a channel dark: the pin is never at level 0.
- R3: Mode code 2'b01 keeps a channel lit with no PWM: the pin is at level 0 on every cycle.
- R4: With mode code 2'b10, any window of 256*IND_DIV clocks holds exactly duty*IND_DIV lit cycles. A duty of 0 never lights, and a duty of 255 lights 255 of every 256 counts.
- R5: A new channel duty is applied only from the start of the next 256-count individual cycle. A change made mid-cycle does not cut the running lit interval short.
- R6: With mode code 2'b11 and the blink select 0, the channel is lit only when both its own PWM and the group signal are on. The group period is 256*DIM_DIV clocks, and the group signal is on for the first grp_duty of its 256 phase steps.
- R7: With the blink select 1, the group period is (grp_freq+1)*256*BLINK_DIV clocks. The group signal is on for the first grp_duty of its 256 phase steps.
- R8: The group duty, the group frequency and the dim or blink choice are applied only when the group phase wraps from 255 to 0.
- R9: When the enable input is HIGH, the override code acts on all pins at once, without waiting for a clock edge. Code 2'b00 drives level 0, code 2'b01 drives level 1, and codes 2'b10 and 2'b11 release every pin (drive enable 0).
- R10: With open-drain selected, a pin whose value is 1 has drive enable 0, while a pin whose value is 0 is driven LOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable; HIGH applies the override |
| chan_mode | input | 2*N_CH | Per-channel mode, 2 bits each, channel 0 in the low bits |
| chan_duty | input | DUTY_W*N_CH | Per-channel brightness duty, channel 0 in the low bits |
| grp_duty | input | DUTY_W | Group duty |
| grp_freq | input | DUTY_W | Blink period selector |
| grp_blink | input | 1 | 0 selects group dimming, 1 selects group blinking |
| od_sel | input | 1 | 1 selects open-drain pins, 0 selects push-pull |
| oe_state | input | 2 | Override code used while oe_n is HIGH |
| pin_lvl | output | N_CH | Level driven on each pin (0 means LED lit) |
| pin_en | output | N_CH | Drive enable for each pin (0 means released) |

## Verification
The clocked properties assume that every register input changes synchronously to clk and holds steady between edges. The bench therefore changes those inputs only on falling edges. The latch properties also assume that nothing outside the block resets the phase counters. The combinational override checks assume that oe_n and oe_state may change at any time. For that reason the bench toggles them between edges and samples a nanosecond later. Group duties are drawn so that the group on-time is a whole number of 256-clock individual cycles. This keeps each measured lit count free of the phase offset between the two counters.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
    typedef enum logic [1:0] {
        CM_OFF = 2'b00,
        CM_ON  = 2'b01,
        CM_IND = 2'b10,
        CM_GRP = 2'b11
    } chan_mode_e;

    typedef enum logic {
        GS_DIM   = 1'b0,
        GS_BLINK = 1'b1
    } grp_state_e;
endpackage

// File: rtl/led_ind_timebase.sv
module led_ind_timebase #(
    parameter int CNT_W = 8,
    parameter int DIV   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase,
    output logic             cyc_start
);
    logic step;

    generate
        if (DIV > 1) begin : g_pre
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                   pre_q <= '0;
                else if (pre_q == PW'(DIV-1)) pre_q <= '0;
                else                          pre_q <= pre_q + 1'b1;
            end
            assign step = (pre_q == PW'(DIV-1));
        end else begin : g_nopre
            assign step = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase <= '0;
        else if (step) phase <= phase + 1'b1;
    end

    // Pulse on the last step of a cycle: the next count is 0.
    assign cyc_start = step && (phase == '1);
endmodule

// File: rtl/led_grp_ctrl.sv
module led_grp_ctrl
    import led_dim_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DIM_DIV   = 512,
    parameter int BLINK_DIV = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] grp_duty,
    input  logic [CNT_W-1:0] grp_freq,
    input  logic             blink_sel,
    output logic             grp_on
);
    localparam int PRE_MAX = (DIM_DIV > BLINK_DIV) ? DIM_DIV : BLINK_DIV;
    localparam int PRE_W   = $clog2(PRE_MAX + 1);

    grp_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] sub_q, phase_q, gduty_q, freq_q;
    logic             base_tick, step, wrap;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_DIM;
        else        state_q <= state_d;
    end

    // Transitions: ARM_BLINK (dim->blink) and ARM_DIM (blink->dim), only at wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_DIM:   if (wrap && blink_sel)  state_d = GS_BLINK;
            GS_BLINK: if (wrap && !blink_sel) state_d = GS_DIM;
            default:  state_d = GS_DIM;
        endcase
    end

    // Outputs of the machine: tick and step strobes
    always_comb begin
        base_tick = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            GS_DIM: begin
                base_tick = (pre_q == PRE_W'(DIM_DIV - 1));
                step      = base_tick;
            end
            GS_BLINK: begin
                base_tick = (pre_q == PRE_W'(BLINK_DIV - 1));
                step      = base_tick && (sub_q == freq_q);
            end
            default: ;
        endcase
        wrap = step && (phase_q == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            sub_q   <= '0;
            phase_q <= '0;
            gduty_q <= '1;
            freq_q  <= '0;
        end else begin
            pre_q <= base_tick ? '0 : pre_q + 1'b1;
            if (step)                                sub_q <= '0;
            else if (base_tick && state_q == GS_BLINK) sub_q <= sub_q + 1'b1;
            if (step) phase_q <= phase_q + 1'b1;
            if (wrap) begin
                gduty_q <= grp_duty;
                freq_q  <= grp_freq;
            end
        end
    end

    assign grp_on = (phase_q < gduty_q);

    p_gduty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(gduty_q));
    p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(state_q));
    p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(freq_q));
    p_sub_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_BLINK) |-> (sub_q <= freq_q));
endmodule

// File: rtl/led_chan.sv
module led_chan
    import led_dim_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ind_phase,
    input  logic             cyc_start,
    input  logic             grp_on,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] duty,
    output logic             lit
);
    logic [CNT_W-1:0] duty_q;
    logic             ind_on, lit_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         duty_q <= '0;
        else if (cyc_start) duty_q <= duty;
    end

    assign ind_on = (ind_phase < duty_q);

    always_comb begin
        unique case (chan_mode_e'(mode))
            CM_OFF:  lit_d = 1'b0;
            CM_ON:   lit_d = 1'b1;
            CM_IND:  lit_d = ind_on;
            CM_GRP:  lit_d = ind_on && grp_on;
            default: lit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lit <= 1'b0;
        else        lit <= lit_d;
    end

    p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(duty_q));
    p_off_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_OFF) |=> !lit);
    p_on_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_ON) |=> lit);
    p_grp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_GRP && !grp_on) |=> !lit);
endmodule

// File: rtl/led_dim_blink.sv
module led_dim_blink
    import led_dim_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int DUTY_W    = 8,
    parameter int IND_DIV   = 1,
    parameter int DIM_DIV   = 512,
    parameter int BLINK_DIV = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     oe_n,
    input  logic [2*N_CH-1:0]        chan_mode,
    input  logic [DUTY_W*N_CH-1:0]   chan_duty,
    input  logic [DUTY_W-1:0]        grp_duty,
    input  logic [DUTY_W-1:0]        grp_freq,
    input  logic                     grp_blink,
    input  logic                     od_sel,
    input  logic [1:0]               oe_state,
    output logic [N_CH-1:0]          pin_lvl,
    output logic [N_CH-1:0]          pin_en
);
    logic [DUTY_W-1:0] ind_phase;
    logic              cyc_start, grp_on;
    logic [N_CH-1:0]   lit;

    led_ind_timebase #(.CNT_W(DUTY_W), .DIV(IND_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .phase(ind_phase), .cyc_start(cyc_start)
    );

    led_grp_ctrl #(.CNT_W(DUTY_W), .DIM_DIV(DIM_DIV), .BLINK_DIV(BLINK_DIV)) u_grp (
        .clk(clk), .rst_n(rst_n), .grp_duty(grp_duty), .grp_freq(grp_freq),
        .blink_sel(grp_blink), .grp_on(grp_on)
    );

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            led_chan #(.CNT_W(DUTY_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .ind_phase(ind_phase),
                .cyc_start(cyc_start), .grp_on(grp_on),
                .mode(chan_mode[2*ch +: 2]),
                .duty(chan_duty[DUTY_W*ch +: DUTY_W]),
                .lit(lit[ch])
            );
        end
    endgenerate

    // Pin stage: combinational so the override needs no clock edge
    always_comb begin
        for (int ch = 0; ch < N_CH; ch++) begin
            logic val, rel;
            val = ~lit[ch];
            rel = 1'b0;
            if (oe_n) begin
                unique case (oe_state)
                    2'b00:   val = 1'b0;
                    2'b01:   val = 1'b1;
                    default: begin val = 1'b1; rel = 1'b1; end
                endcase
            end
            pin_lvl[ch] = val;
            pin_en[ch]  = !(rel || (od_sel && val));
        end
    end

    always_comb begin
        if (oe_n && oe_state[1]) begin
            p_oe_hiz_r9: assert (pin_en == '0);
        end
        if (od_sel) begin
            p_od_release_r10: assert ((pin_lvl & pin_en) == '0);
        end
    end

    p_rst_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (lit == '0));
endmodule

// File: tb/led_dim_blink_tb_top.sv
module led_dim_blink_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n, oe_n, grp_blink, od_sel;
    logic [1:0]       oe_state;
    logic [2*NCH-1:0] chan_mode;
    logic [8*NCH-1:0] chan_duty;
    logic [7:0]       grp_duty, grp_freq;
    logic [NCH-1:0]   pin_lvl, pin_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int cnt[NCH];
    int md[NCH];
    int dd[NCH];
    int cur_per = 512;

    led_dim_blink #(.N_CH(NCH), .DUTY_W(8), .IND_DIV(1), .DIM_DIV(2), .BLINK_DIV(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .chan_mode(chan_mode),
        .chan_duty(chan_duty), .grp_duty(grp_duty), .grp_freq(grp_freq),
        .grp_blink(grp_blink), .od_sel(od_sel), .oe_state(oe_state),
        .pin_lvl(pin_lvl), .pin_en(pin_en)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(bit bl, int f);
        return bl ? (f + 1) * 256 : 512;
    endfunction

    function automatic int exp_low(int m, int d, int g, bit bl, int f);
        int w = period_of(bl, f);
        int st = bl ? f + 1 : 2;
        case (m)
            0: return 0;
            1: return w;
            2: return (w / 256) * d;
            default: return ((g * st) / 256) * d;
        endcase
    endfunction

    function automatic string tag_of(int m, bit bl);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return bl ? "R7" : "R6";
        endcase
    endfunction

    task automatic measure(int w);
        for (int i = 0; i < NCH; i++) cnt[i] = 0;
        repeat (w) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++)
                if (pin_lvl[i] == 1'b0 && pin_en[i]) cnt[i]++;
        end
    endtask

    task automatic run_cfg(bit bl, int f, int g);
        int np;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            chan_mode[2*i +: 2] = 2'(md[i]);
            chan_duty[8*i +: 8] = 8'(dd[i]);
        end
        grp_duty = 8'(g);
        grp_freq = 8'(f);
        grp_blink = bl;
        np = period_of(bl, f);
        repeat (cur_per + np + 300) @(negedge clk);
        cur_per = np;
        measure(np);
        for (int i = 0; i < NCH; i++)
            chk(tag_of(md[i], bl), cnt[i], exp_low(md[i], dd[i], g, bl, f));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int run, prev, fsel, k;
        void'($urandom(32'd4242));
        rst_n = 1'b0; oe_n = 1'b0; od_sel = 1'b0; oe_state = 2'b10;
        grp_blink = 1'b0; grp_duty = 8'hFF; grp_freq = 8'h00;
        chan_mode = {NCH{2'b01}}; chan_duty = '1;
        repeat (5) @(negedge clk);
        // R1: reset dominates even with every channel in the lit mode
        chk("R1 lvl", int'(pin_lvl), 4'hF);
        chk("R1 en", int'(pin_en), 4'hF);
        chan_mode = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed duty boundaries (R4), dim grouping (R6), blink grouping (R7)
        md = '{2, 2, 0, 1}; dd = '{0, 255, 77, 10};
        run_cfg(1'b0, 0, 128);
        md = '{3, 3, 3, 2}; dd = '{200, 255, 0, 128};
        run_cfg(1'b0, 0, 128);
        md = '{3, 3, 2, 0}; dd = '{100, 1, 33, 9};
        run_cfg(1'b1, 3, 192);
        md = '{3, 3, 3, 3}; dd = '{50, 60, 70, 80};
        run_cfg(1'b1, 1, 0);

        // Random configurations
        for (int it = 0; it < 12; it++) begin
            bit bl;
            int f, g;
            bl = 1'($urandom % 2);
            fsel = $urandom % 3;
            f = (fsel == 0) ? 1 : (fsel == 1) ? 3 : 7;
            if (bl) begin
                k = $urandom % (f + 1);
                g = k * 256 / (f + 1);
            end else begin
                g = ($urandom % 2) * 128;
            end
            for (int i = 0; i < NCH; i++) begin
                md[i] = $urandom % 4;
                dd[i] = $urandom % 256;
            end
            run_cfg(bl, f, g);
        end

        // R5: duty change mid-cycle keeps the running lit interval
        md = '{2, 0, 0, 0}; dd = '{128, 0, 0, 0};
        run_cfg(1'b0, 0, 255);
        prev = 0;
        for (int w = 0; w < 600; w++) begin
            @(negedge clk);
            if (prev == 1 && pin_lvl[0] == 1'b0) break;
            prev = pin_lvl[0];
        end
        repeat (10) @(negedge clk);
        chan_duty[7:0] = 8'd0;
        repeat (50) @(negedge clk);
        chk("R5 held", int'(pin_lvl[0]), 0);
        repeat (300) @(negedge clk);
        measure(256);
        chk("R5 applied", cnt[0], 0);

        // R8: group duty change mid-period waits for the wrap
        md = '{3, 0, 0, 0}; dd = '{255, 0, 0, 0};
        run_cfg(1'b0, 0, 128);
        run = 0;
        for (int w = 0; w < 1200; w++) begin
            @(negedge clk);
            if (pin_lvl[0] == 1'b0 && run >= 100) break;
            run = pin_lvl[0] ? run + 1 : 0;
        end
        repeat (20) @(negedge clk);
        grp_duty = 8'd0;
        repeat (30) @(negedge clk);
        measure(150);
        chk("R8 held", (cnt[0] >= 149) ? 1 : 0, 1);
        repeat (1200) @(negedge clk);
        measure(512);
        chk("R8 applied", cnt[0], 0);

        // R9: asynchronous override, sampled between edges
        md = '{1, 0, 1, 0};
        chan_mode = 8'b00_01_00_01;
        repeat (4) @(negedge clk);
        #1 oe_n = 1'b1; oe_state = 2'b00;
        #1 chk("R9 low lvl", int'(pin_lvl), 0);
        chk("R9 low en", int'(pin_en), 4'hF);
        oe_state = 2'b01;
        #1 chk("R9 high lvl", int'(pin_lvl), 4'hF);
        chk("R9 high en", int'(pin_en), 4'hF);
        oe_state = 2'b11;
        #1 chk("R9 hiz en", int'(pin_en), 0);
        // R10: open-drain releases logic 1
        od_sel = 1'b1; oe_state = 2'b01;
        #1 chk("R10 od override", int'(pin_en), 0);
        oe_n = 1'b0;
        #1 chk("R10 od lvl", int'(pin_lvl), 4'b1010);
        chk("R10 od en", int'(pin_en), 4'b0101);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule